// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits beside one processor and decides which interrupt, if any, that processor is shown. It keeps the processor's current priority threshold, a software inter-processor-interrupt (IPI) request priority, the number and priority of the one pending source, and a flag recording that some offer was turned away. Interrupt sources make delivery offers to it. Each offer is answered one cycle later with an accept or a refusal. An accepted offer can displace the source that was pending, and the displaced source is reported so that it can be offered again.

The processor works the block through four register operations. It can claim the pending interrupt, change its priority threshold, set the IPI priority, or signal end of interrupt. The block drives a level interrupt line that always reflects its stored state. It also emits pulses that ask the sources to rescan for refused offers and that forward end-of-interrupt to a source. Lower numeric priority is more favored. A pending priority of all ones means nothing is pending, and source number 0 means no source. The IPI uses a reserved source number, 2 by default.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the IPI priority is 0xFF, the pending priority is 0xFF and the pending source is 0. The line `irq_out` is low, and a claim returns 0x00000000.
- R2: An offer with priority p is accepted only when p is strictly below the threshold, the IPI priority and the pending priority. On acceptance the offered source and p become pending, and `offer_ack` pulses in the next cycle.
- R3: A refused offer pulses `offer_nak` in the next cycle and sets the need-resend flag.
- R4: When an accepted offer displaces a pending source, that source is reported on `rej_src` with `rej_valid` in the next cycle.
- R5: `irq_out` is high exactly when the pending source is nonzero and the pending priority is below the threshold.
- R6: A claim (`op_code` 0) returns {threshold, pending source}, with the threshold in bits 31:24 and the source in bits 23:0, on `rd_data` with `rd_valid` one cycle later. If a source was pending, the threshold takes the pending priority and the pending state clears.
- R7: An IPI priority write (`op_code` 2, value in `op_data[31:24]`) stores the value. If the value is below the threshold and not above the pending priority, the pending source is rejected, and the IPI number becomes pending at that priority.
- R8: An IPI priority write with a value greater than the old one clears the need-resend flag. If the flag was set, it pulses `resend_req`.
- R9: A threshold write (`op_code` 1, value in `op_data[31:24]`) equal to the current threshold changes nothing. A smaller value is loaded, and a pending source whose priority is not below it is rejected and cleared.
- R10: A threshold write with a larger value loads it. If the IPI priority is below the new threshold and not above the pending priority, the IPI is made pending. The need-resend flag is then cleared, with a `resend_req` pulse if it was set.
- R11: An end-of-interrupt (`op_code` 3) loads the threshold from bits 31:24 by the rule of R10 without any reject check. It pulses `eoi_valid` with `eoi_src` = bits 23:0, unless that source is the IPI number.
- R12: A rejected source equal to the IPI number, or equal to 0, is never reported on `rej_valid`.
- R13: When an operation and an offer arrive in the same cycle, the operation takes effect, the offer is refused, and need-resend is left set after the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | Delivery offer present this cycle |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| op_valid | input | 1 | Processor operation present this cycle |
| op_code | input | 2 | 0 claim, 1 threshold write, 2 IPI priority write, 3 end of interrupt |
| op_data | input | 32 | Operation data: priority in 31:24, source in 23:0 |
| offer_ack | output | 1 | Offer accepted (one cycle after offer) |
| offer_nak | output | 1 | Offer refused (one cycle after offer) |
| rej_valid | output | 1 | A displaced source is reported |
| rej_src | output | 24 | Displaced source number |
| rd_valid | output | 1 | Claim result valid |
| rd_data | output | 32 | Claim result |
| resend_req | output | 1 | Request that sources rescan refused offers |
| eoi_valid | output | 1 | End-of-interrupt forwarded |
| eoi_src | output | 24 | Source receiving end-of-interrupt |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
An offer and a processor operation can land in the same cycle. The case that matters is a raise of the threshold that clears need-resend while the offer is being refused. The bench drives both in one cycle: an offer below the old threshold together with a threshold raise while need-resend is set. It expects `resend_req` and `offer_nak` together. It then raises the IPI priority and expects a second `resend_req`, which shows that the refusal set need-resend again after the operation had cleared it.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;
  localparam int SRC_W  = 24;
  localparam int PRI_W  = 8;
  localparam int WORD_W = SRC_W + PRI_W;

  typedef logic [SRC_W-1:0] src_t;
  typedef logic [PRI_W-1:0] pri_t;

  localparam pri_t PRI_IDLE = '1;

  typedef enum logic [1:0] {
    OP_CLAIM = 2'd0,
    OP_THRESH = 2'd1,
    OP_IPIPRI = 2'd2,
    OP_EOI = 2'd3
  } op_e;

  typedef struct packed {
    pri_t thresh;
    pri_t ipi_pri;
    pri_t pend_pri;
    src_t pend_src;
    logic need_resend;
  } ipr_state_t;

  localparam ipr_state_t STATE_RESET = '{
    thresh: '0, ipi_pri: PRI_IDLE, pend_pri: PRI_IDLE,
    pend_src: '0, need_resend: 1'b0};
endpackage

// File: rtl/ipr_offer_eval.sv
module ipr_offer_eval
  import irq_presenter_pkg::*;
(
  input  ipr_state_t st,
  input  pri_t       pri,
  output logic       take
);
  // An offer must beat every priority currently in force.
  always_comb begin
    take = (pri < st.thresh) && (pri < st.ipi_pri) && (pri < st.pend_pri);
  end
endmodule

// File: rtl/ipr_op_unit.sv
module ipr_op_unit
  import irq_presenter_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  ipr_state_t        st,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [WORD_W-1:0] op_data,
  output ipr_state_t        nx,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output src_t              rej_src,
  output logic              resend,
  output logic              eoi_valid,
  output src_t              eoi_src
);
  localparam src_t IPI_ID = src_t'(IPI_SRC);

  pri_t val;
  src_t arg_src;
  logic lower;

  assign val     = op_data[WORD_W-1:SRC_W];
  assign arg_src = op_data[SRC_W-1:0];

  always_comb begin
    nx        = st;
    rd_valid  = 1'b0;
    rd_data   = '0;
    rej_src   = '0;
    resend    = 1'b0;
    eoi_valid = 1'b0;
    eoi_src   = '0;
    lower     = 1'b0;
    if (op_valid) begin
      unique case (op_e'(op_code))
        OP_CLAIM: begin
          rd_valid = 1'b1;
          rd_data  = {st.thresh, st.pend_src};
          if (st.pend_src != '0) begin
            nx.thresh   = st.pend_pri;
            nx.pend_pri = PRI_IDLE;
            nx.pend_src = '0;
          end
        end
        OP_IPIPRI: begin
          nx.ipi_pri = val;
          if ((val < st.thresh) && (val <= st.pend_pri)) begin
            rej_src     = st.pend_src;
            nx.pend_pri = val;
            nx.pend_src = IPI_ID;
          end
          if (val > st.ipi_pri) begin
            resend         = st.need_resend;
            nx.need_resend = 1'b0;
          end
        end
        OP_THRESH: begin
          if (val < st.thresh) begin
            nx.thresh = val;
            if (val <= st.pend_pri) begin
              rej_src     = st.pend_src;
              nx.pend_src = '0;
              nx.pend_pri = PRI_IDLE;
            end
          end else if (val > st.thresh) begin
            lower = 1'b1;
          end
        end
        OP_EOI: begin
          lower     = 1'b1;
          eoi_valid = (arg_src != IPI_ID);
          eoi_src   = arg_src;
        end
        default: ;
      endcase
    end
    // Threshold relaxation shared by threshold raise and end of interrupt.
    if (lower) begin
      nx.thresh = val;
      if ((st.ipi_pri < val) && (st.ipi_pri <= st.pend_pri)) begin
        nx.pend_pri = st.ipi_pri;
        nx.pend_src = IPI_ID;
      end
      resend         = st.need_resend;
      nx.need_resend = 1'b0;
    end
  end
endmodule

// File: rtl/ipr_state_reg.sv
module ipr_state_reg
  import irq_presenter_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  ipr_state_t d,
  output ipr_state_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= STATE_RESET;
    else if (en) q <= d;
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        offer_valid,
  input  logic [23:0] offer_src,
  input  logic [7:0]  offer_pri,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic [31:0] op_data,
  output logic        offer_ack,
  output logic        offer_nak,
  output logic        rej_valid,
  output logic [23:0] rej_src,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        resend_req,
  output logic        eoi_valid,
  output logic [23:0] eoi_src,
  output logic        irq_out
);
  localparam src_t IPI_ID = src_t'(IPI_SRC);

  ipr_state_t st_q, st_op, st_d;
  logic              op_rd_v, op_resend, op_eoi_v, take, step_en;
  logic [WORD_W-1:0] op_rd;
  src_t              op_rej, op_eoi_src, rej_raw;
  logic              ack_d, nak_d, rej_v_d;

  ipr_op_unit #(.IPI_SRC(IPI_SRC)) u_op (
    .st(st_q), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .nx(st_op), .rd_valid(op_rd_v), .rd_data(op_rd), .rej_src(op_rej),
    .resend(op_resend), .eoi_valid(op_eoi_v), .eoi_src(op_eoi_src)
  );

  ipr_offer_eval u_eval (.st(st_q), .pri(offer_pri), .take(take));

  // Operation wins a shared cycle; the offer is then refused.
  always_comb begin
    st_d    = st_op;
    ack_d   = 1'b0;
    nak_d   = 1'b0;
    rej_raw = op_rej;
    if (offer_valid) begin
      if (!op_valid && take) begin
        ack_d         = 1'b1;
        rej_raw       = st_q.pend_src;
        st_d.pend_src = offer_src;
        st_d.pend_pri = offer_pri;
      end else begin
        nak_d            = 1'b1;
        st_d.need_resend = 1'b1;
      end
    end
    rej_v_d = (rej_raw != '0) && (rej_raw != IPI_ID);
  end

  assign step_en = op_valid | offer_valid;

  ipr_state_reg u_state (.clk(clk), .rst_n(rst_n), .en(step_en), .d(st_d), .q(st_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_ack  <= 1'b0;
      offer_nak  <= 1'b0;
      rej_valid  <= 1'b0;
      rd_valid   <= 1'b0;
      resend_req <= 1'b0;
      eoi_valid  <= 1'b0;
    end else begin
      offer_ack  <= ack_d;
      offer_nak  <= nak_d;
      rej_valid  <= rej_v_d;
      rd_valid   <= op_rd_v;
      resend_req <= op_resend;
      eoi_valid  <= op_eoi_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_src <= '0;
      rd_data <= '0;
      eoi_src <= '0;
    end else begin
      if (rej_v_d)  rej_src <= rej_raw;
      if (op_rd_v)  rd_data <= op_rd;
      if (op_eoi_v) eoi_src <= op_eoi_src;
    end
  end

  assign irq_out = (st_q.pend_src != '0) && (st_q.pend_pri < st_q.thresh);
endmodule

// File: rtl/irq_presenter_checker.sv
module irq_presenter_checker #(
  parameter int IPI_SRC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        offer_valid,
  input logic        op_valid,
  input logic [1:0]  op_code,
  input logic        offer_ack,
  input logic        offer_nak,
  input logic        rej_valid,
  input logic [23:0] rej_src,
  input logic        rd_valid,
  input logic        eoi_valid,
  input logic [23:0] eoi_src,
  input logic        irq_out
);
  localparam logic [23:0] IPI_ID = 24'(IPI_SRC);

  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(offer_ack && offer_nak));
  p_offer_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |=> (offer_ack || offer_nak));
  p_no_stray_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !offer_valid |=> !(offer_ack || offer_nak));
  p_shared_cycle_refused_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && op_valid) |=> offer_nak);
  p_reject_filter_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != IPI_ID) && (rej_src != '0));
  p_eoi_filter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> (eoi_src != IPI_ID));
  p_claim_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd0) |=> rd_valid);
  p_claim_drops_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd0) |=> !irq_out);
endmodule

bind irq_presenter irq_presenter_checker #(.IPI_SRC(IPI_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .op_valid(op_valid),
  .op_code(op_code), .offer_ack(offer_ack), .offer_nak(offer_nak),
  .rej_valid(rej_valid), .rej_src(rej_src), .rd_valid(rd_valid),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
);

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_pri = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        offer_ack, offer_nak, rej_valid, rd_valid, resend_req, eoi_valid, irq_out;
  logic [23:0] rej_src, eoi_src;
  logic [31:0] rd_data;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_pri(offer_pri), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .offer_ack(offer_ack), .offer_nak(offer_nak), .rej_valid(rej_valid),
    .rej_src(rej_src), .rd_valid(rd_valid), .rd_data(rd_data),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    logic        rd_v;
    logic [31:0] rd;
    logic        ack;
    logic        nak;
    logic [23:0] rej;
    logic        resend;
    logic        eoi_v;
    logic [23:0] eoi;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every expected item in the cycle it falls due.
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      logic bad;
      e = exp_q.pop_front();
      bad = (rd_valid !== e.rd_v) || (e.rd_v && rd_data !== e.rd) ||
            (offer_ack !== e.ack) || (offer_nak !== e.nak) ||
            (rej_valid !== (e.rej != 0)) || ((e.rej != 0) && rej_src !== e.rej) ||
            (resend_req !== e.resend) || (eoi_valid !== e.eoi_v) ||
            (e.eoi_v && eoi_src !== e.eoi) || (irq_out !== e.irq);
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s: actual rd=%b/%h ack=%b nak=%b rej=%b/%h rs=%b eoi=%b/%h irq=%b expected rd=%b/%h ack=%b nak=%b rej=%h rs=%b eoi=%b/%h irq=%b",
          e.tag, rd_valid, rd_data, offer_ack, offer_nak, rej_valid, rej_src,
          resend_req, eoi_valid, eoi_src, irq_out, e.rd_v, e.rd, e.ack, e.nak,
          e.rej, e.resend, e.eoi_v, e.eoi, e.irq);
      end
    end
  end

  // Driver: applies one cycle of stimulus and queues its expected result.
  task automatic step(input logic ov, input logic [23:0] os, input logic [7:0] opr,
                      input logic pv, input logic [1:0] pc, input logic [31:0] pd,
                      input logic x_rd_v, input logic [31:0] x_rd, input logic x_ack,
                      input logic x_nak, input logic [23:0] x_rej, input logic x_rs,
                      input logic x_eoi_v, input logic [23:0] x_eoi, input logic x_irq,
                      input string tag);
    exp_t e;
    @(negedge clk);
    offer_valid = ov; offer_src = os; offer_pri = opr;
    op_valid = pv; op_code = pc; op_data = pd;
    e.due = cyc + 1; e.rd_v = x_rd_v; e.rd = x_rd; e.ack = x_ack; e.nak = x_nak;
    e.rej = x_rej; e.resend = x_rs; e.eoi_v = x_eoi_v; e.eoi = x_eoi;
    e.irq = x_irq; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (irq_out !== 1'b0 || rd_valid !== 1'b0 || offer_ack !== 1'b0 || resend_req !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual irq=%b rd=%b ack=%b rs=%b expected 0 0 0 0",
               irq_out, rd_valid, offer_ack, resend_req);
    end
    //   ov os       pri    pv pc     pd           rdv rd            ack nak rej       rs eoiv eoi       irq
    step(0, 24'h0,   8'h0,  1, 2'd0, 32'h0,        1, 32'h00000000, 0, 0, 24'h0,   0, 0, 24'h0,   0, "R1 claim at reset");
    step(1, 24'h100, 8'h05, 0, 2'd0, 32'h0,        0, 32'h0,        0, 1, 24'h0,   0, 0, 24'h0,   0, "R3 refused by masked threshold");
    step(0, 24'h0,   8'h0,  1, 2'd1, 32'hFF000000, 0, 32'h0,        0, 0, 24'h0,   1, 0, 24'h0,   0, "R10 threshold raise resends");
    step(1, 24'h100, 8'h05, 0, 2'd0, 32'h0,        0, 32'h0,        1, 0, 24'h0,   0, 0, 24'h0,   1, "R2 R5 offer accepted");
    step(1, 24'h200, 8'h03, 0, 2'd0, 32'h0,        0, 32'h0,        1, 0, 24'h100, 0, 0, 24'h0,   1, "R4 better offer displaces");
    step(1, 24'h300, 8'h03, 0, 2'd0, 32'h0,        0, 32'h0,        0, 1, 24'h0,   0, 0, 24'h0,   1, "R2 R3 equal priority refused");
    step(0, 24'h0,   8'h0,  1, 2'd0, 32'h0,        1, 32'hFF000200, 0, 0, 24'h0,   0, 0, 24'h0,   0, "R6 claim pending");
    step(0, 24'h0,   8'h0,  1, 2'd1, 32'h03000000, 0, 32'h0,        0, 0, 24'h0,   0, 0, 24'h0,   0, "R9 equal threshold no effect");
    step(0, 24'h0,   8'h0,  1, 2'd2, 32'h01000000, 0, 32'h0,        0, 0, 24'h0,   0, 0, 24'h0,   1, "R7 IPI presented");
    step(1, 24'h400, 8'h00, 0, 2'd0, 32'h0,        0, 32'h0,        1, 0, 24'h0,   0, 0, 24'h0,   1, "R12 displaced IPI not reported");
    step(0, 24'h0,   8'h0,  1, 2'd2, 32'h10000000, 0, 32'h0,        0, 0, 24'h0,   1, 0, 24'h0,   1, "R8 IPI priority raise resends");
    step(0, 24'h0,   8'h0,  1, 2'd1, 32'h00000000, 0, 32'h0,        0, 0, 24'h400, 0, 0, 24'h0,   0, "R9 smaller threshold rejects");
    step(0, 24'h0,   8'h0,  1, 2'd1, 32'h20000000, 0, 32'h0,        0, 0, 24'h0,   0, 0, 24'h0,   1, "R10 raise presents IPI");
    step(0, 24'h0,   8'h0,  1, 2'd0, 32'h0,        1, 32'h20000002, 0, 0, 24'h0,   0, 0, 24'h0,   0, "R6 claim IPI");
    step(0, 24'h0,   8'h0,  1, 2'd3, 32'hFF000002, 0, 32'h0,        0, 0, 24'h0,   0, 0, 24'h0,   1, "R11 IPI end of interrupt not forwarded");
    step(0, 24'h0,   8'h0,  1, 2'd0, 32'h0,        1, 32'hFF000002, 0, 0, 24'h0,   0, 0, 24'h0,   0, "R6 claim reissued IPI");
    step(0, 24'h0,   8'h0,  1, 2'd2, 32'hFF000000, 0, 32'h0,        0, 0, 24'h0,   0, 0, 24'h0,   0, "R8 raise without flag");
    step(0, 24'h0,   8'h0,  1, 2'd3, 32'h30000123, 0, 32'h0,        0, 0, 24'h0,   0, 1, 24'h123, 0, "R11 end of interrupt forwarded");
    step(1, 24'h500, 8'h31, 0, 2'd0, 32'h0,        0, 32'h0,        0, 1, 24'h0,   0, 0, 24'h0,   0, "R3 refused above threshold");
    step(1, 24'h500, 8'h20, 1, 2'd1, 32'h50000000, 0, 32'h0,        0, 1, 24'h0,   1, 0, 24'h0,   0, "R13 shared cycle");
    step(0, 24'h0,   8'h0,  1, 2'd2, 32'h40000000, 0, 32'h0,        0, 0, 24'h0,   0, 0, 24'h0,   1, "R7 IPI below new threshold");
    step(0, 24'h0,   8'h0,  1, 2'd2, 32'h60000000, 0, 32'h0,        0, 0, 24'h0,   1, 0, 24'h0,   1, "R13 flag kept after shared cycle");
    @(negedge clk);
    offer_valid = 1'b0; op_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual %0d items left expected 0", exp_q.size());
    end
    summary();
  end
endmodule